// File: doc/BRIEF.md
# Post-Increment Load/Store Address Unit

This block sits beside the integer pipeline of a 32-bit RISC-V core. It accepts one custom load or store instruction at a time, together with the operand values already read from the register file. It turns that instruction into one memory request: address, access size, byte enables and, for stores, the write data laid out across the byte lanes. Addresses come from a base register plus an offset. The offset is either a sign-extended 12-bit immediate or a second register. In post-increment form the unmodified base is the address, and the sum is written back to the base register. In indexed form the sum is the address, and the base is left untouched.

When the memory response arrives, the block returns the results in that same cycle. For loads it returns the lane-selected and extended load value for the destination register. For post-increment forms it also returns the updated base. If a post-increment load names the same register as destination and base, the loaded value wins. The base update is dropped and a collide flag is raised. Encodings outside the supported set produce a one-cycle illegal pulse and no memory traffic.

The controller has four states:
- IDLE accepts requests.
- ISSUE presents the memory request.
- WAIT waits for the response.
- FAULT signals an illegal encoding.

The transitions are:
- IDLE→ISSUE when a legal instruction is accepted.
- IDLE→FAULT when an illegal one is accepted.
- ISSUE→WAIT when the memory port takes the request.
- WAIT→IDLE when the response arrives.
- FAULT→IDLE after one cycle.

Top module: `pinc_lsu`

## Requirements
- R1: Immediate post-increment loads use opcode 0001011 with funct3 000 (signed byte), 100 (unsigned byte), 001 (signed half), 101 (unsigned half) or 010 (word). The address is rs1, and the base writeback to rs1 (instr[19:15]) is rs1 + sign-extended instr[31:20].
- R2: Register-offset loads use funct3 111, with funct7 0000000 (signed byte), 0100000 (unsigned byte), 0001000 (signed half), 0101000 (unsigned half) or 0010000 (word). With opcode 0001011 the address is rs1 and the base writeback is rs1 + rs2. With opcode 0000011 the address is rs1 + rs2 and there is no base writeback.
- R3: Immediate post-increment stores use opcode 0101011 with funct3 000/001/010 for byte/half/word. The offset is sign-extended {instr[31:25], instr[11:7]}, the address is rs1, and the base writeback is rs1 + offset.
- R4: Register-offset stores use funct7 0000000 and funct3 100/101/110 for byte/half/word. The offset is the value of the register indexed by instr[11:7], presented on req_rs3. Opcode 0101011 is post-increment (address rs1, base writeback rs1 + rs3). Opcode 0100011 is indexed (address rs1 + rs3, no base writeback).
- R5: The load value is taken from the response word. A byte comes from bits 8n+7:8n, where n is address bits 1:0. A half comes from bits 31:16 when address bit 1 is set, and from bits 15:0 otherwise. Signed variants sign-extend, unsigned variants zero-extend, and words pass unchanged. The value is written back to rd = instr[11:7].
- R6: mem_req_size is 0 for byte, 1 for half and 2 for word. The byte enable is bit n for a byte access at lane n, 0011 or 1100 for a half access (chosen by address bit 1), and 1111 for a word. Store data repeats the low byte four times, or the low half twice. mem_req_we is 1 only for stores.
- R7: A post-increment load with rd equal to rs1 writes back only the loaded value, with no base writeback, and raises wb_collide in the response cycle.
- R8: req_ready is high only in IDLE. The memory request stays valid and stable until mem_req_ready. Each instruction makes exactly one request.
- R9: Writebacks are raised only in the cycle in which mem_rsp_valid arrives during WAIT. Stores never raise the data writeback.
- R10: Any other encoding makes no memory request. It gives a one-cycle req_illegal pulse in the cycle after acceptance, and then the block returns to IDLE.
- R11: Out of reset the block is in IDLE, with req_ready high and every request, writeback and illegal output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Block idle, instruction taken this cycle |
| req_instr | input | 32 | Instruction word |
| req_rs1 | input | DW | Base register value |
| req_rs2 | input | DW | Load offset register or store data value |
| req_rs3 | input | DW | Store offset register value (index instr[11:7]) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | DW | Byte address |
| mem_req_we | output | 1 | Store when high |
| mem_req_size | output | 2 | 0 byte, 1 half, 2 word |
| mem_req_be | output | DW/8 | Byte enables |
| mem_req_wdata | output | DW | Lane-replicated store data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | DW | Aligned response word |
| wb_data_valid | output | 1 | Load value writeback |
| wb_data_idx | output | RIDX_W | Destination register index |
| wb_data_value | output | DW | Extended load value |
| wb_base_valid | output | 1 | Base register writeback |
| wb_base_idx | output | RIDX_W | Base register index |
| wb_base_value | output | DW | Base plus offset |
| wb_collide | output | 1 | Destination equals base on a post-increment load |
| req_illegal | output | 1 | Unsupported encoding pulse |

## Verification
The bench builds the block with its default parameters: DW = 32 and RIDX_W = 5. That width brings all four byte lanes and both half lanes within reach, along with the sign bit of each lane. It also covers the two split halves of the store immediate, including their sign bit. The stimulus covers every load and store variant in both post-increment and indexed form. It uses negative offsets and the extreme immediates 0x7FF and 0x800. It includes a base-equals-destination load, request stalls and delayed responses, and four kinds of unsupported encoding.

// File: rtl/pinc_lsu_pkg.sv
package pinc_lsu_pkg;

    localparam logic [6:0] OPC_LD_PINC = 7'b0001011;
    localparam logic [6:0] OPC_LD_IDX  = 7'b0000011;
    localparam logic [6:0] OPC_ST_PINC = 7'b0101011;
    localparam logic [6:0] OPC_ST_IDX  = 7'b0100011;
    localparam logic [2:0] F3_LD_REG   = 3'b111;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_FAULT
    } lsu_state_e;

    typedef struct packed {
        logic      legal;
        logic      store;
        logic      post_inc;
        logic      imm_off;
        logic      zero_ext;
        acc_size_e size;
    } lsu_op_t;

endpackage

// File: rtl/pinc_lsu_decode.sv
module pinc_lsu_decode
    import pinc_lsu_pkg::*;
#(
    parameter int DW     = 32,
    parameter int RIDX_W = 5
) (
    input  logic [31:0]       instr,
    output lsu_op_t           op,
    output logic [DW-1:0]     imm_ext,
    output logic [RIDX_W-1:0] rd_idx,
    output logic [RIDX_W-1:0] rs1_idx
);

    logic [6:0]  opc;
    logic [6:0]  f7;
    logic [2:0]  f3;
    logic [11:0] imm_ld;
    logic [11:0] imm_st;

    assign opc     = instr[6:0];
    assign f3      = instr[14:12];
    assign f7      = instr[31:25];
    assign imm_ld  = instr[31:20];
    assign imm_st  = {instr[31:25], instr[11:7]};
    assign rd_idx  = RIDX_W'(instr[11:7]);
    assign rs1_idx = RIDX_W'(instr[19:15]);

    // {legal, zero_ext, size} for immediate-form loads
    function automatic logic [3:0] ld_by_f3(input logic [2:0] f);
        case (f)
            3'b000:  return {1'b1, 1'b0, SZ_BYTE};
            3'b100:  return {1'b1, 1'b1, SZ_BYTE};
            3'b001:  return {1'b1, 1'b0, SZ_HALF};
            3'b101:  return {1'b1, 1'b1, SZ_HALF};
            3'b010:  return {1'b1, 1'b0, SZ_WORD};
            default: return 4'b0000;
        endcase
    endfunction

    // {legal, zero_ext, size} for register-offset loads
    function automatic logic [3:0] ld_by_f7(input logic [6:0] f);
        case (f)
            7'b0000000: return {1'b1, 1'b0, SZ_BYTE};
            7'b0100000: return {1'b1, 1'b1, SZ_BYTE};
            7'b0001000: return {1'b1, 1'b0, SZ_HALF};
            7'b0101000: return {1'b1, 1'b1, SZ_HALF};
            7'b0010000: return {1'b1, 1'b0, SZ_WORD};
            default:    return 4'b0000;
        endcase
    endfunction

    always_comb begin
        op = '0;
        case (opc)
            OPC_LD_PINC: begin
                op.post_inc = 1'b1;
                if (f3 == F3_LD_REG) begin
                    {op.legal, op.zero_ext, op.size} = ld_by_f7(f7);
                end else begin
                    {op.legal, op.zero_ext, op.size} = ld_by_f3(f3);
                    op.imm_off = 1'b1;
                end
            end
            OPC_LD_IDX: begin
                if (f3 == F3_LD_REG) begin
                    {op.legal, op.zero_ext, op.size} = ld_by_f7(f7);
                end
            end
            OPC_ST_PINC: begin
                op.store    = 1'b1;
                op.post_inc = 1'b1;
                op.imm_off  = !f3[2];
                op.size     = acc_size_e'(f3[1:0]);
                op.legal    = (f3[1:0] != 2'b11) && (!f3[2] || (f7 == 7'd0));
            end
            OPC_ST_IDX: begin
                op.store = 1'b1;
                op.size  = acc_size_e'(f3[1:0]);
                op.legal = f3[2] && (f3[1:0] != 2'b11) && (f7 == 7'd0);
            end
            default: ;
        endcase
        if (!op.legal) begin
            op = '0;
        end
    end

    assign imm_ext = op.store ? {{(DW-12){imm_st[11]}}, imm_st}
                              : {{(DW-12){imm_ld[11]}}, imm_ld};

endmodule

// File: rtl/pinc_lsu_agen.sv
module pinc_lsu_agen
    import pinc_lsu_pkg::*;
#(
    parameter int DW = 32
) (
    input  lsu_op_t          op,
    input  logic [DW-1:0]    base,
    input  logic [DW-1:0]    imm_ext,
    input  logic [DW-1:0]    reg_off,
    input  logic [DW-1:0]    store_src,
    output logic [DW-1:0]    addr,
    output logic [DW-1:0]    base_next,
    output logic [DW-1:0]    wdata,
    output logic [DW/8-1:0]  be
);

    localparam int LANES  = DW / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int HW     = LANE_W - 1;

    logic [DW-1:0]     offset;
    logic [LANE_W-1:0] lane;

    assign offset    = op.imm_off ? imm_ext : reg_off;
    assign base_next = base + offset;
    assign addr      = op.post_inc ? base : base_next;
    assign lane      = addr[LANE_W-1:0];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (op.size)
                SZ_BYTE: begin
                    be[i]          = (lane == LANE_W'(i));
                    wdata[i*8 +: 8] = store_src[7:0];
                end
                SZ_HALF: begin
                    be[i]          = (lane[LANE_W-1:1] == HW'(i / 2));
                    wdata[i*8 +: 8] = store_src[(i % 2)*8 +: 8];
                end
                default: begin
                    be[i]          = 1'b1;
                    wdata[i*8 +: 8] = store_src[i*8 +: 8];
                end
            endcase
        end
    end

endmodule

// File: rtl/pinc_lsu_ldext.sv
module pinc_lsu_ldext
    import pinc_lsu_pkg::*;
#(
    parameter int DW = 32
) (
    input  acc_size_e                   size,
    input  logic                        zero_ext,
    input  logic [$clog2(DW/8)-1:0]     lane,
    input  logic [DW-1:0]               rdata,
    output logic [DW-1:0]               value
);

    localparam int LANE_W = $clog2(DW / 8);

    logic [LANE_W-1:0] lane_eff;
    logic [LANE_W+2:0] shamt;
    logic [DW-1:0]     shifted;
    logic              fill;

    assign lane_eff = (size == SZ_HALF) ? {lane[LANE_W-1:1], 1'b0} : lane;
    assign shamt    = {lane_eff, 3'b000};
    assign shifted  = rdata >> shamt;

    always_comb begin
        fill = 1'b0;
        unique case (size)
            SZ_BYTE: begin
                fill  = !zero_ext && shifted[7];
                value = {{(DW-8){fill}}, shifted[7:0]};
            end
            SZ_HALF: begin
                fill  = !zero_ext && shifted[15];
                value = {{(DW-16){fill}}, shifted[15:0]};
            end
            default: value = rdata;
        endcase
    end

endmodule

// File: rtl/pinc_lsu.sv
module pinc_lsu
    import pinc_lsu_pkg::*;
#(
    parameter int DW     = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_instr,
    input  logic [DW-1:0]     req_rs1,
    input  logic [DW-1:0]     req_rs2,
    input  logic [DW-1:0]     req_rs3,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [DW-1:0]     mem_req_addr,
    output logic              mem_req_we,
    output logic [1:0]        mem_req_size,
    output logic [DW/8-1:0]   mem_req_be,
    output logic [DW-1:0]     mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_rdata,
    output logic              wb_data_valid,
    output logic [RIDX_W-1:0] wb_data_idx,
    output logic [DW-1:0]     wb_data_value,
    output logic              wb_base_valid,
    output logic [RIDX_W-1:0] wb_base_idx,
    output logic [DW-1:0]     wb_base_value,
    output logic              wb_collide,
    output logic              req_illegal
);

    localparam int LANES  = DW / 8;
    localparam int LANE_W = $clog2(LANES);

    lsu_state_e st_q, st_d;

    lsu_op_t           dec_op;
    logic [DW-1:0]     dec_imm;
    logic [RIDX_W-1:0] dec_rd;
    logic [RIDX_W-1:0] dec_rs1;
    logic [DW-1:0]     ag_addr, ag_next, ag_wdata;
    logic [LANES-1:0]  ag_be;
    logic              accept_ok;
    logic              rsp_take;

    lsu_op_t           c_op;
    logic [DW-1:0]     c_addr, c_next, c_wdata;
    logic [LANES-1:0]  c_be;
    logic [RIDX_W-1:0] c_rd, c_rs1;
    logic              c_coll;

    pinc_lsu_decode #(.DW(DW), .RIDX_W(RIDX_W)) u_dec (
        .instr   (req_instr),
        .op      (dec_op),
        .imm_ext (dec_imm),
        .rd_idx  (dec_rd),
        .rs1_idx (dec_rs1)
    );

    pinc_lsu_agen #(.DW(DW)) u_agen (
        .op        (dec_op),
        .base      (req_rs1),
        .imm_ext   (dec_imm),
        .reg_off   (dec_op.store ? req_rs3 : req_rs2),
        .store_src (req_rs2),
        .addr      (ag_addr),
        .base_next (ag_next),
        .wdata     (ag_wdata),
        .be        (ag_be)
    );

    pinc_lsu_ldext #(.DW(DW)) u_ext (
        .size     (c_op.size),
        .zero_ext (c_op.zero_ext),
        .lane     (c_addr[LANE_W-1:0]),
        .rdata    (mem_rsp_rdata),
        .value    (wb_data_value)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d          = st_q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        req_illegal   = 1'b0;
        rsp_take      = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    st_d = dec_op.legal ? S_ISSUE : S_FAULT;
                end
            end
            S_ISSUE: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    st_d = S_WAIT;
                end
            end
            S_WAIT: begin
                rsp_take = mem_rsp_valid;
                if (mem_rsp_valid) begin
                    st_d = S_IDLE;
                end
            end
            S_FAULT: begin
                req_illegal = 1'b1;
                st_d        = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    assign accept_ok = (st_q == S_IDLE) && req_valid && dec_op.legal;

    // captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_op    <= '0;
            c_addr  <= '0;
            c_next  <= '0;
            c_wdata <= '0;
            c_be    <= '0;
            c_rd    <= '0;
            c_rs1   <= '0;
            c_coll  <= 1'b0;
        end else if (accept_ok) begin
            c_op    <= dec_op;
            c_addr  <= ag_addr;
            c_next  <= ag_next;
            c_wdata <= ag_wdata;
            c_be    <= ag_be;
            c_rd    <= dec_rd;
            c_rs1   <= dec_rs1;
            c_coll  <= !dec_op.store && dec_op.post_inc && (dec_rd == dec_rs1);
        end
    end

    assign mem_req_addr  = c_addr;
    assign mem_req_we    = c_op.store;
    assign mem_req_size  = c_op.size;
    assign mem_req_be    = c_be;
    assign mem_req_wdata = c_wdata;

    assign wb_data_valid = rsp_take && !c_op.store;
    assign wb_data_idx   = c_rd;
    assign wb_base_valid = rsp_take && c_op.post_inc && !c_coll;
    assign wb_base_idx   = c_rs1;
    assign wb_base_value = c_next;
    assign wb_collide    = rsp_take && c_coll;

endmodule

// File: rtl/pinc_lsu_chk.sv
module pinc_lsu_chk #(
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [DW-1:0]   mem_req_addr,
    input logic            mem_req_we,
    input logic [1:0]      mem_req_size,
    input logic [DW/8-1:0] mem_req_be,
    input logic [DW-1:0]   mem_req_wdata,
    input logic            mem_rsp_valid,
    input logic            wb_data_valid,
    input logic            wb_base_valid,
    input logic            wb_collide,
    input logic            req_illegal
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_be) && $stable(mem_req_wdata)); // R8
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R8
    AST_WB_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_data_valid || wb_base_valid || wb_collide) |-> mem_rsp_valid && !mem_req_valid); // R9
    AST_STORE_NO_DATA_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid && mem_req_we |-> !wb_data_valid); // R9
    AST_COLLIDE_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_collide |-> wb_data_valid && !wb_base_valid); // R7
    AST_BYTE_BE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_size == 2'd0 |-> $countones(mem_req_be) == 1); // R6
    AST_HALF_BE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_size == 2'd1 |-> $countones(mem_req_be) == 2); // R6
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_illegal |=> !req_illegal && req_ready); // R10
    AST_ILLEGAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_illegal |-> !mem_req_valid); // R10

endmodule

bind pinc_lsu pinc_lsu_chk #(.DW(DW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_we    (mem_req_we),
    .mem_req_size  (mem_req_size),
    .mem_req_be    (mem_req_be),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .wb_data_valid (wb_data_valid),
    .wb_base_valid (wb_base_valid),
    .wb_collide    (wb_collide),
    .req_illegal   (req_illegal)
);

// File: tb/pinc_lsu_tb_top.sv
module pinc_lsu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_instr = '0;
    logic [31:0] req_rs1 = '0, req_rs2 = '0, req_rs3 = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_req_we;
    logic [1:0]  mem_req_size;
    logic [3:0]  mem_req_be;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        wb_data_valid;
    logic [4:0]  wb_data_idx;
    logic [31:0] wb_data_value;
    logic        wb_base_valid;
    logic [4:0]  wb_base_idx;
    logic [31:0] wb_base_value;
    logic        wb_collide;
    logic        req_illegal;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pinc_lsu #(.DW(32), .RIDX_W(5)) dut_i (.*);

    typedef struct {
        bit          ill;
        logic [31:0] addr;
        bit          we;
        logic [3:0]  be;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [31:0] rdata;
        bit          dv;
        logic [4:0]  drd;
        logic [31:0] dval;
        bit          bv;
        logic [4:0]  brd;
        logic [31:0] bval;
        bit          coll;
        int          stall;
        int          gap;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t cur;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(logic [6:0] f7, logic [4:0] a, logic [4:0] b,
                                        logic [2:0] f3, logic [4:0] c, logic [6:0] op);
        return {f7, a, b, f3, c, op};
    endfunction

    function automatic item_t ld(string tag, logic [31:0] addr, logic [3:0] be, logic [1:0] size,
                                 logic [31:0] rdata, logic [31:0] dval, bit bv, logic [31:0] bval);
        item_t it;
        it = '{default: 0, tag: ""};
        it.tag = tag; it.addr = addr; it.be = be; it.size = size; it.rdata = rdata;
        it.dv = 1; it.drd = 5'd5; it.dval = dval; it.bv = bv; it.brd = 5'd6; it.bval = bval;
        return it;
    endfunction

    function automatic item_t st(string tag, logic [31:0] addr, logic [3:0] be, logic [1:0] size,
                                 logic [31:0] wdata, bit bv, logic [31:0] bval);
        item_t it;
        it = '{default: 0, tag: ""};
        it.tag = tag; it.addr = addr; it.we = 1; it.be = be; it.size = size; it.wdata = wdata;
        it.rdata = 32'h0; it.bv = bv; it.brd = 5'd8; it.bval = bval;
        return it;
    endfunction

    function automatic item_t bad(string tag);
        item_t it;
        it = '{default: 0, tag: ""};
        it.tag = tag; it.ill = 1;
        return it;
    endfunction

    // driver: queue the expectation, then offer the instruction
    task automatic send(input item_t it, input logic [31:0] ins, input logic [31:0] r1,
                        input logic [31:0] r2, input logic [31:0] r3);
        do @(negedge clk); while (exp_q.size() != 0 || !req_ready);
        exp_q.push_back(it);
        req_valid = 1'b1; req_instr = ins; req_rs1 = r1; req_rs2 = r2; req_rs3 = r3;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor / memory model
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                cur = exp_q[0];
                if (req_illegal) begin
                    chk(cur.tag, "illegal pulse expected", 32'(cur.ill), 32'd1);
                    chk("R10", "no request with illegal", 32'(mem_req_valid), 32'd0);
                    void'(exp_q.pop_front());
                end else if (mem_req_valid) begin
                    chk(cur.tag, "request issued", 32'(!cur.ill), 32'd1);
                    chk(cur.tag, "address", mem_req_addr, cur.addr);
                    chk("R6", "write enable", 32'(mem_req_we), 32'(cur.we));
                    chk("R6", "byte enables", 32'(mem_req_be), 32'(cur.be));
                    chk("R6", "size", 32'(mem_req_size), 32'(cur.size));
                    if (cur.we) chk("R6", "store data", mem_req_wdata, cur.wdata);
                    chk("R8", "ready low while busy", 32'(req_ready), 32'd0);
                    for (int k = 0; k < cur.stall; k++) begin
                        @(negedge clk);
                        chk("R8", "request held", 32'(mem_req_valid), 32'd1);
                        chk("R8", "address stable", mem_req_addr, cur.addr);
                    end
                    mem_req_ready = 1'b1;
                    @(negedge clk);
                    mem_req_ready = 1'b0;
                    chk("R8", "single request", 32'(mem_req_valid), 32'd0);
                    for (int k = 0; k < cur.gap; k++) begin
                        chk("R9", "no writeback before response",
                            32'({wb_data_valid, wb_base_valid, wb_collide}), 32'd0);
                        @(negedge clk);
                    end
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = cur.rdata;
                    #1;
                    chk(cur.dv ? "R5" : "R9", "data wb valid", 32'(wb_data_valid), 32'(cur.dv));
                    if (cur.dv) begin
                        chk("R5", "data wb index", 32'(wb_data_idx), 32'(cur.drd));
                        chk("R5", "data wb value", wb_data_value, cur.dval);
                    end
                    chk(cur.tag, "base wb valid", 32'(wb_base_valid), 32'(cur.bv));
                    if (cur.bv) begin
                        chk(cur.tag, "base wb index", 32'(wb_base_idx), 32'(cur.brd));
                        chk(cur.tag, "base wb value", wb_base_value, cur.bval);
                    end
                    chk("R7", "collide flag", 32'(wb_collide), 32'(cur.coll));
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                    chk("R9", "writeback drops after response",
                        32'({wb_data_valid, wb_base_valid}), 32'd0);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog: actual hung expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stimulus
        item_t it;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "ready in reset", 32'(req_ready), 32'd1);
        chk("R11", "no request in reset", 32'(mem_req_valid), 32'd0);
        chk("R11", "no writeback in reset", 32'({wb_data_valid, wb_base_valid, wb_collide}), 32'd0);
        chk("R11", "no illegal in reset", 32'(req_illegal), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "ready after reset", 32'(req_ready), 32'd1);

        // R1 immediate post-increment loads
        send(ld("R1", 32'h2000_0001, 4'b0010, 2'd0, 32'h1234_F078, 32'hFFFF_FFF0, 1, 32'h1FFF_FFFD),
             enc(7'h7F, 5'h1C, 5'd6, 3'b000, 5'd5, 7'b0001011), 32'h2000_0001, 0, 0);
        send(ld("R1", 32'h2000_0003, 4'b1000, 2'd0, 32'h9A00_0000, 32'h0000_009A, 1, 32'h2000_0006),
             enc(7'h00, 5'h03, 5'd6, 3'b100, 5'd5, 7'b0001011), 32'h2000_0003, 0, 0);
        send(ld("R1", 32'h0000_0102, 4'b1100, 2'd1, 32'h8001_5555, 32'hFFFF_8001, 1, 32'h0000_0901),
             enc(7'h3F, 5'h1F, 5'd6, 3'b001, 5'd5, 7'b0001011), 32'h0000_0102, 0, 0);
        send(ld("R1", 32'h0000_1000, 4'b0011, 2'd1, 32'h1111_C0DE, 32'h0000_C0DE, 1, 32'h0000_0800),
             enc(7'h40, 5'h00, 5'd6, 3'b101, 5'd5, 7'b0001011), 32'h0000_1000, 0, 0);
        it = ld("R1", 32'h0000_0040, 4'b1111, 2'd2, 32'h8765_4321, 32'h8765_4321, 1, 32'h0000_0044);
        it.stall = 3; it.gap = 2;
        send(it, enc(7'h00, 5'h04, 5'd6, 3'b010, 5'd5, 7'b0001011), 32'h0000_0040, 0, 0);

        // R2 register-offset loads
        send(ld("R2", 32'h3000_0000, 4'b0001, 2'd0, 32'h0000_0080, 32'hFFFF_FF80, 1, 32'h3000_0010),
             enc(7'b0000000, 5'd2, 5'd6, 3'b111, 5'd5, 7'b0001011), 32'h3000_0000, 32'h10, 0);
        send(ld("R2", 32'h0000_0102, 4'b1100, 2'd1, 32'hFEDC_0000, 32'h0000_FEDC, 0, 0),
             enc(7'b0101000, 5'd2, 5'd6, 3'b111, 5'd5, 7'b0000011), 32'h0000_0100, 32'h2, 0);
        it = ld("R2", 32'h0000_01FC, 4'b1111, 2'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 0);
        it.stall = 2; it.gap = 1;
        send(it, enc(7'b0010000, 5'd2, 5'd6, 3'b111, 5'd5, 7'b0000011), 32'h0000_0200, 32'hFFFF_FFFC, 0);
        send(ld("R2", 32'h0000_0005, 4'b0010, 2'd0, 32'h0000_FF00, 32'h0000_00FF, 0, 0),
             enc(7'b0100000, 5'd2, 5'd6, 3'b111, 5'd5, 7'b0000011), 32'h0000_0005, 32'h0, 0);
        send(ld("R2", 32'h0000_0010, 4'b0011, 2'd1, 32'hAAAA_7FFF, 32'h0000_7FFF, 1, 32'h0000_0012),
             enc(7'b0001000, 5'd2, 5'd6, 3'b111, 5'd5, 7'b0001011), 32'h0000_0010, 32'h2, 0);
        send(ld("R2", 32'h0000_0080, 4'b1111, 2'd2, 32'h8000_0000, 32'h8000_0000, 1, 32'h0000_0088),
             enc(7'b0010000, 5'd2, 5'd6, 3'b111, 5'd5, 7'b0001011), 32'h0000_0080, 32'h8, 0);
        send(ld("R2", 32'h0000_0007, 4'b1000, 2'd0, 32'h8000_0000, 32'hFFFF_FF80, 0, 0),
             enc(7'b0000000, 5'd2, 5'd6, 3'b111, 5'd5, 7'b0000011), 32'h0000_0007, 32'h0, 0);

        // R7 destination equals base
        it = ld("R7", 32'h0000_0900, 4'b1111, 2'd2, 32'h0BAD_F00D, 32'h0BAD_F00D, 0, 0);
        it.drd = 5'd7; it.coll = 1;
        send(it, enc(7'h00, 5'h08, 5'd7, 3'b010, 5'd7, 7'b0001011), 32'h0000_0900, 0, 0);

        // R3 immediate post-increment stores
        send(st("R3", 32'h5000_0002, 4'b0100, 2'd0, 32'hABAB_ABAB, 1, 32'h5000_0001),
             enc(7'h7F, 5'd9, 5'd8, 3'b000, 5'h1F, 7'b0101011), 32'h5000_0002, 32'h1234_56AB, 0);
        send(st("R3", 32'h6000_0002, 4'b1100, 2'd1, 32'h1234_1234, 1, 32'h6000_0022),
             enc(7'h01, 5'd9, 5'd8, 3'b001, 5'h00, 7'b0101011), 32'h6000_0002, 32'hAAAA_1234, 0);
        send(st("R3", 32'h0000_1000, 4'b1111, 2'd2, 32'hCAFE_F00D, 1, 32'h0000_0F80),
             enc(7'h7C, 5'd9, 5'd8, 3'b010, 5'h00, 7'b0101011), 32'h0000_1000, 32'hCAFE_F00D, 0);

        // R4 register-offset stores
        send(st("R4", 32'h8000_0003, 4'b1000, 2'd0, 32'h5555_5555, 1, 32'h8000_0103),
             enc(7'h00, 5'd9, 5'd8, 3'b100, 5'd3, 7'b0101011), 32'h8000_0003, 32'h0000_0055, 32'h100);
        send(st("R4", 32'h0000_0012, 4'b1100, 2'd1, 32'hBEEF_BEEF, 0, 0),
             enc(7'h00, 5'd9, 5'd8, 3'b101, 5'd3, 7'b0100011), 32'h0000_0010, 32'h0000_BEEF, 32'h2);
        send(st("R4", 32'h0000_0024, 4'b1111, 2'd2, 32'h0102_0304, 0, 0),
             enc(7'h00, 5'd9, 5'd8, 3'b110, 5'd3, 7'b0100011), 32'h0000_0020, 32'h0102_0304, 32'h4);

        // R10 unsupported encodings
        send(bad("R10"), enc(7'h00, 5'd0, 5'd6, 3'b011, 5'd5, 7'b0001011), 32'h10, 0, 0);
        send(bad("R10"), enc(7'b0000001, 5'd9, 5'd8, 3'b100, 5'd3, 7'b0100011), 32'h10, 0, 0);
        send(bad("R10"), enc(7'b0000001, 5'd2, 5'd6, 3'b111, 5'd5, 7'b0000011), 32'h10, 0, 0);
        send(bad("R10"), enc(7'h00, 5'd0, 5'd6, 3'b000, 5'd5, 7'b0000011), 32'h10, 0, 0);

        // recovery after illegal
        send(ld("R1", 32'h0000_0044, 4'b0001, 2'd0, 32'h0000_007F, 32'h0000_007F, 1, 32'h0000_0045),
             enc(7'h00, 5'h01, 5'd6, 3'b000, 5'd5, 7'b0001011), 32'h0000_0044, 0, 0);

        do @(negedge clk); while (exp_q.size() != 0);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule